// File: doc/BRIEF.md
# Character-Cell Overlay Raster Generator

This block turns a text screen of 24 columns by 12 rows into a 1-bit overlay pixel stream. It is meant to be keyed over a television picture. The pixel-rate raster counters come in from an external timing generator. For every dot the block finds the character cell and the dot inside that cell, and works out the character code. It then reads that dot from a built-in 64-glyph font of 12×18 dots and registers the result onto `pix_o`.

Each row has its own row register, which picks one of 64 generated 24-cell line patterns. A pattern holds fixed codes and "variable" cells. Variable cells take their code from a 176-entry display RAM. The RAM entries are handed out in display order: row by row, left to right, starting at entry 0. A write port loads the RAM and the row registers. The window position, the horizontal and vertical magnification (1 to 4) and the blink enable are plain inputs. A blink phase, stepped by vertical sync, can hide any cell whose blink attribute is set.

Top module: `osd_raster`

## Requirements
- R1: Reset behaviour.
  - After reset `pix_o` is 0.
  - Every RAM entry and row register is zero. This selects pattern 0 with no blink attribute.
  - The blink phase is visible.
- R2: Window geometry.
  - The text window starts at dot x0 = 4·`hpos_i` and line y0 = 4·`vpos_i`.
  - It is 24·12·(`hsize_i`+1) dots wide and 12·18·(`vsize_i`+1) lines high.
  - Column = (h−x0)/(12·(`hsize_i`+1)) and row = (v−y0)/(18·(`vsize_i`+1)).
- R3: A dot outside the text window gives `pix_o` = 0.
- R4: Magnification.
  - Each font dot column is repeated `hsize_i`+1 times across.
  - Each font dot line is repeated `vsize_i`+1 times down.
- R5: Row register bits [5:0] give the pattern number p.
  - Cell c is variable when p ≥ 32 and c < p−32.
  - Otherwise the cell is fixed, with code (p+c) mod 64.
- R6: Variable cells take consecutive display RAM entries.
  - The order is display order: rows top to bottom, cells left to right, starting at entry 0.
  - A cell whose entry number is 176 or more shows code 0 and has no blink attribute.
- R7: Font rule.
  - Code 0 is blank.
  - For code k, a dot is lit when its dot column equals k mod 12 or its dot line equals k mod 18.
- R8: Write port, active when `wr_en_i` = 1.
  - Address a < 176 loads RAM entry a from `wr_data_i`: bits [5:0] are the code and bit 6 is the blink attribute.
  - Address 176+r loads row register r: bits [5:0] are the pattern and bit 6 is the row blink attribute.
- R9: Blinking.
  - The blink phase starts visible and toggles on every 32nd rising edge of `vsync_i`.
  - While `blink_en_i` = 1 and the phase is hidden, a cell whose blink attribute is set outputs 0. For a variable cell the attribute is the RAM entry's bit 6; for a fixed cell it is the row's bit 6.
- R10: Timing.
  - The counters sampled at clock edge k set `pix_o` at edge k+1.
  - `hcnt_i` must advance by one per clock along a line and pass 0 at the start of each line.
  - The vertical state advances only on a cycle with `hcnt_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hcnt_i | input | 11 | Horizontal dot counter |
| vcnt_i | input | 10 | Vertical line counter |
| vsync_i | input | 1 | Vertical sync; its rising edges step the blink counter |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address (RAM entries, then row registers) |
| wr_data_i | input | 7 | Write data: code or pattern [5:0], blink attribute [6] |
| hpos_i | input | 6 | Horizontal start, in units of 4 dots |
| vpos_i | input | 6 | Vertical start, in units of 4 lines |
| hsize_i | input | 2 | Horizontal magnification minus one |
| vsize_i | input | 2 | Vertical magnification minus one |
| blink_en_i | input | 1 | Enables blink gating |
| pix_o | output | 1 | Overlay pixel |

## Verification
The bench checks both edges of the window: the dot just before x0, the line at y0, and the line just after the last row. A design that counted the pitch wrongly would shift or clip whole cells. It checks every magnification step. An off-by-one in the repeat counter would stretch the glyphs unevenly and move every later column. It runs a screen whose patterns ask for more than 176 variable cells. A design that wrapped or saturated the entry number would show stale RAM codes where blanks belong. It fires exactly 31 and then 32 vsync edges. A blink counter that toggled one edge early or late would hide or show the flagged cells in the wrong frame.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int CODE_W = 6;
  localparam int ATTR_W = CODE_W + 1;

  function automatic logic cell_is_var(input logic [CODE_W-1:0] pat, input int col);
    return pat[CODE_W-1] && (col < int'(pat[CODE_W-2:0]));
  endfunction

  function automatic int var_count(input logic [CODE_W-1:0] pat, input int cols);
    int n;
    n = pat[CODE_W-1] ? int'(pat[CODE_W-2:0]) : 0;
    return (n > cols) ? cols : n;
  endfunction

  function automatic logic [CODE_W-1:0] fixed_code(input logic [CODE_W-1:0] pat, input int col);
    return CODE_W'(int'(pat) + col);
  endfunction

  function automatic logic glyph_dot(input logic [CODE_W-1:0] code, input int dx, input int dy,
                                     input int cw, input int ch);
    int k;
    k = int'(code);
    return (k != 0) && ((dx == k % cw) || (dy == k % ch));
  endfunction
endpackage

// File: rtl/osd_store.sv
module osd_store import osd_pkg::*; #(
  parameter int DEPTH  = 176,
  parameter int ROWS   = 12,
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 9,
  parameter int ROW_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ATTR_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [ATTR_W-1:0] slot_attr_o,
  output logic [ATTR_W-1:0] row_attr_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [ATTR_W-1:0] mem_q  [DEPTH];
  logic [ATTR_W-1:0] rows_q [ROWS];

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i)) mem_q[i] <= wr_data_i;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rows_q[r] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(DEPTH + r)) rows_q[r] <= wr_data_i;
    end
  end

  // entries past the end read as a blank, non-blinking code
  assign slot_attr_o = (int'(rd_slot_i) < DEPTH) ? mem_q[rd_slot_i[IDX_W-1:0]] : '0;
  assign row_attr_o  = (int'(rd_row_i) < ROWS) ? rows_q[rd_row_i] : '0;
endmodule

// File: rtl/osd_scan.sv
module osd_scan import osd_pkg::*; #(
  parameter int COLS   = 24,
  parameter int ROWS   = 12,
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  parameter int HW     = 11,
  parameter int VW     = 10,
  parameter int POS_W  = 6,
  parameter int SIZE_W = 2,
  parameter int SLOT_W = 9,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 4,
  parameter int DX_W   = 4,
  parameter int DY_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW-1:0]     hcnt_i,
  input  logic [VW-1:0]     vcnt_i,
  input  logic [POS_W-1:0]  hpos_i,
  input  logic [POS_W-1:0]  vpos_i,
  input  logic [SIZE_W-1:0] hsize_i,
  input  logic [SIZE_W-1:0] vsize_i,
  input  logic [CODE_W-1:0] row_pat_i,
  output logic              h_act_o,
  output logic              v_act_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [DX_W-1:0]   dx_o,
  output logic [DY_W-1:0]   dy_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [HW-1:0] x0;
  logic [VW-1:0] y0;
  assign x0 = HW'({hpos_i, 2'b00});
  assign y0 = VW'({vpos_i, 2'b00});

  logic              v_act_q, v_act_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [DY_W-1:0]   dy_q, dy_n;
  logic [SIZE_W-1:0] vrep_q, vrep_n;
  logic [SLOT_W-1:0] base_q, base_n;

  logic              h_act_q, h_act_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [DX_W-1:0]   dx_q, dx_n;
  logic [SIZE_W-1:0] hrep_q, hrep_n;
  logic [SLOT_W-1:0] slot_q, slot_n;

  // vertical: evaluated once per line, at hcnt_i == 0
  always_comb begin
    v_act_n = v_act_q;
    row_n   = row_q;
    dy_n    = dy_q;
    vrep_n  = vrep_q;
    base_n  = base_q;
    if (hcnt_i == '0) begin
      if (vcnt_i == y0) begin
        v_act_n = 1'b1;
        row_n   = '0;
        dy_n    = '0;
        vrep_n  = '0;
        base_n  = '0;
      end else if (v_act_q) begin
        if (vrep_q == vsize_i) begin
          vrep_n = '0;
          if (dy_q == DY_W'(CELL_H - 1)) begin
            dy_n   = '0;
            base_n = base_q + SLOT_W'(var_count(row_pat_i, COLS));
            if (row_q == ROW_W'(ROWS - 1)) v_act_n = 1'b0;
            else                           row_n   = row_q + 1'b1;
          end else begin
            dy_n = dy_q + 1'b1;
          end
        end else begin
          vrep_n = vrep_q + 1'b1;
        end
      end
    end
  end

  // horizontal: one dot per clock from x0
  always_comb begin
    h_act_n = h_act_q;
    col_n   = col_q;
    dx_n    = dx_q;
    hrep_n  = hrep_q;
    slot_n  = slot_q;
    if (hcnt_i == x0) begin
      h_act_n = 1'b1;
      col_n   = '0;
      dx_n    = '0;
      hrep_n  = '0;
      slot_n  = base_n;
    end else if (h_act_q) begin
      if (hrep_q == hsize_i) begin
        hrep_n = '0;
        if (dx_q == DX_W'(CELL_W - 1)) begin
          dx_n = '0;
          if (cell_is_var(row_pat_i, int'(col_q))) slot_n = slot_q + 1'b1;
          if (col_q == COL_W'(COLS - 1)) h_act_n = 1'b0;
          else                           col_n   = col_q + 1'b1;
        end else begin
          dx_n = dx_q + 1'b1;
        end
      end else begin
        hrep_n = hrep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_act_q <= 1'b0; row_q <= '0; dy_q <= '0; vrep_q <= '0; base_q <= '0;
      h_act_q <= 1'b0; col_q <= '0; dx_q <= '0; hrep_q <= '0; slot_q <= '0;
    end else begin
      v_act_q <= v_act_n; row_q <= row_n; dy_q <= dy_n; vrep_q <= vrep_n; base_q <= base_n;
      h_act_q <= h_act_n; col_q <= col_n; dx_q <= dx_n; hrep_q <= hrep_n; slot_q <= slot_n;
    end
  end

  assign h_act_o = h_act_q;
  assign v_act_o = v_act_q;
  assign col_o   = col_q;
  assign row_o   = row_q;
  assign dx_o    = dx_q;
  assign dy_o    = dy_q;
  assign slot_o  = slot_q;

  p_col_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_act_q |-> (int'(col_q) < COLS && int'(dx_q) < CELL_W));

  p_row_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_act_q |-> (int'(row_q) < ROWS && int'(dy_q) < CELL_H));

  p_hstart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(h_act_q) |-> (col_q == '0 && dx_q == '0 && $past(hcnt_i) == $past(x0)));

  // within a line the entry number never skips
  p_slot_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_act_q && $past(h_act_q) && $past(hcnt_i) != $past(x0))
      |-> (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/osd_blink.sv
module osd_blink #(
  parameter int FRAMES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic hidden_o
);
  localparam int CNT_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;

  logic             vs_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  assign rise = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q    <= 1'b0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      if (rise) begin
        if (cnt_q == CNT_W'(FRAMES - 1)) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign hidden_o = phase_q;

  p_phase_on_vsync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> $past(rise));
endmodule

// File: rtl/osd_raster.sv
module osd_raster import osd_pkg::*; #(
  parameter int COLS         = 24,
  parameter int ROWS         = 12,
  parameter int CELL_W       = 12,
  parameter int CELL_H       = 18,
  parameter int RAM_DEPTH    = 176,
  parameter int HW           = 11,
  parameter int VW           = 10,
  parameter int POS_W        = 6,
  parameter int SIZE_W       = 2,
  parameter int ADDR_W       = 8,
  parameter int BLINK_FRAMES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW-1:0]     hcnt_i,
  input  logic [VW-1:0]     vcnt_i,
  input  logic              vsync_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ATTR_W-1:0] wr_data_i,
  input  logic [POS_W-1:0]  hpos_i,
  input  logic [POS_W-1:0]  vpos_i,
  input  logic [SIZE_W-1:0] hsize_i,
  input  logic [SIZE_W-1:0] vsize_i,
  input  logic              blink_en_i,
  output logic              pix_o
);
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int DX_W   = $clog2(CELL_W);
  localparam int DY_W   = $clog2(CELL_H);
  localparam int SLOT_W = $clog2(RAM_DEPTH + COLS * ROWS + 1);

  logic              h_act, v_act, hidden;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [DX_W-1:0]   dx;
  logic [DY_W-1:0]   dy;
  logic [SLOT_W-1:0] slot;
  logic [ATTR_W-1:0] slot_attr, row_attr;

  osd_store #(
    .DEPTH(RAM_DEPTH), .ROWS(ROWS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .ROW_W(ROW_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_slot_i(slot), .rd_row_i(row),
    .slot_attr_o(slot_attr), .row_attr_o(row_attr)
  );

  osd_scan #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H), .HW(HW), .VW(VW),
    .POS_W(POS_W), .SIZE_W(SIZE_W), .SLOT_W(SLOT_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .DX_W(DX_W), .DY_W(DY_W)
  ) u_scan (
    .clk_i, .rst_ni, .hcnt_i, .vcnt_i, .hpos_i, .vpos_i, .hsize_i, .vsize_i,
    .row_pat_i(row_attr[CODE_W-1:0]),
    .h_act_o(h_act), .v_act_o(v_act), .col_o(col), .row_o(row),
    .dx_o(dx), .dy_o(dy), .slot_o(slot)
  );

  osd_blink #(.FRAMES(BLINK_FRAMES)) u_blink (
    .clk_i, .rst_ni, .vsync_i, .hidden_o(hidden)
  );

  logic              is_var, blinkable, lit;
  logic [CODE_W-1:0] code;

  always_comb begin
    is_var    = cell_is_var(row_attr[CODE_W-1:0], int'(col));
    code      = is_var ? slot_attr[CODE_W-1:0] : fixed_code(row_attr[CODE_W-1:0], int'(col));
    blinkable = is_var ? slot_attr[CODE_W] : row_attr[CODE_W];
    lit       = h_act && v_act && glyph_dot(code, int'(dx), int'(dy), CELL_W, CELL_H)
                && !(blink_en_i && hidden && blinkable);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= 1'b0;
    else         pix_o <= lit;
  end

  p_pix_needs_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o |-> ($past(h_act) && $past(v_act)));
endmodule

// File: tb/sim_osd_raster.sv
module sim_osd_raster;
  localparam int COLS = 24, ROWS = 12, CW = 12, CH = 18, DEPTH = 176;
  localparam int IDLE_H = 2047, IDLE_V = 1023;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [10:0] hcnt = 11'(IDLE_H);
  logic [9:0]  vcnt = 10'(IDLE_V);
  logic       vsync = 1'b0, wr_en = 1'b0, ben = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [5:0] hpos = '0, vpos = '0;
  logic [1:0] hsz = '0, vsz = '0;
  logic       pix;

  osd_raster u0 (
    .clk_i(clk), .rst_ni(rst_n), .hcnt_i(hcnt), .vcnt_i(vcnt), .vsync_i(vsync),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hpos_i(hpos), .vpos_i(vpos), .hsize_i(hsz), .vsize_i(vsz),
    .blink_en_i(ben), .pix_o(pix)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int ram_m [DEPTH];
  int row_m [ROWS];
  bit phase_m = 0;
  int pulses_m = 0;
  bit d1_ok = 0, d2_ok = 0;
  int d1_exp = 0, d2_exp = 0;
  string d1_tag = "", d2_tag = "";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int vc(int r);
    int p = row_m[r] & 63;
    if (p < 32) return 0;
    return (p - 32 > COLS) ? COLS : p - 32;
  endfunction

  function automatic int exp_pix(int h, int v, output string tag);
    int mh = int'(hsz) + 1, mv = int'(vsz) + 1;
    int cw = CW * mh, ch = CH * mv;
    int x0 = 4 * int'(hpos), y0 = 4 * int'(vpos);
    int col, row, dx, dy, pat, code, bl, slot;
    bit var_c, lit;
    if (h < x0 || h >= x0 + COLS * cw || v < y0 || v >= y0 + ROWS * ch) begin
      tag = "R2 R3";
      return 0;
    end
    col = (h - x0) / cw;  dx = ((h - x0) % cw) / mh;
    row = (v - y0) / ch;  dy = ((v - y0) % ch) / mv;
    pat = row_m[row] & 63;
    var_c = (pat >= 32) && (col < pat - 32);
    if (var_c) begin
      slot = col;
      for (int r = 0; r < row; r++) slot += vc(r);
      code = (slot < DEPTH) ? (ram_m[slot] & 63) : 0;
      bl   = (slot < DEPTH) ? ((ram_m[slot] >> 6) & 1) : 0;
      tag  = "R6 R8";
    end else begin
      code = (pat + col) % 64;
      bl   = (row_m[row] >> 6) & 1;
      tag  = (mh > 1 || mv > 1) ? "R4 R7" : "R5 R7 R10";
    end
    lit = (code != 0) && (dx == code % CW || dy == code % CH);
    if (lit && ben && phase_m && bl != 0) begin
      tag = "R9";
      return 0;
    end
    return int'(lit);
  endfunction

  // output for counters driven at negedge n is compared at negedge n+2 (R10)
  task automatic dot(int h, int v, bit vs = 1'b0);
    @(negedge clk);
    if (d2_ok) chk(d2_tag, int'(pix), d2_exp);
    d2_ok = d1_ok; d2_exp = d1_exp; d2_tag = d1_tag;
    d1_exp = exp_pix(h, v, d1_tag);
    d1_ok = 1;
    hcnt = 11'(h); vcnt = 10'(v); vsync = vs;
  endtask

  task automatic flush();
    dot(IDLE_H, IDLE_V);
    dot(IDLE_H, IDLE_V);
    dot(IDLE_H, IDLE_V);
    d1_ok = 0; d2_ok = 0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 7'(d);
    if (a < DEPTH) ram_m[a] = d & 127;
    else if (a < DEPTH + ROWS) row_m[a - DEPTH] = d & 127;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_vs(int n);
    for (int i = 0; i < n; i++) begin
      dot(IDLE_H, IDLE_V, 1'b1);
      dot(IDLE_H, IDLE_V, 1'b0);
      pulses_m++;
      if (pulses_m % 32 == 0) phase_m = ~phase_m;
    end
  endtask

  task automatic frame(int stride);
    int cw = CW * (int'(hsz) + 1), ch = CH * (int'(vsz) + 1);
    int x0 = 4 * int'(hpos), y0 = 4 * int'(vpos);
    int xend = x0 + COLS * cw, yend = y0 + ROWS * ch;
    for (int v = 0; v <= yend; v++) begin
      if (v % stride == 0 || v == y0 || v == yend - 1 || v == yend) begin
        for (int h = (x0 > 0 ? 0 : 0); h <= xend; h++) begin
          if (h == 0 || h >= x0 - 1) dot(h, v);
          else if (h == 1) begin
            // jump over the empty lead-in; counters only need to reach x0 in order
            for (int k = 1; k < x0 - 1; k++) dot(k, v);
            h = (x0 > 2) ? x0 - 2 : h;
          end
        end
      end else begin
        dot(0, v);
      end
    end
    flush();
  endtask

  task automatic load_random(int pat_lo, int pat_span, bit blink_rand);
    for (int r = 0; r < ROWS; r++)
      wr(DEPTH + r, ((pat_lo + int'($urandom % pat_span)) & 63) |
                    ((blink_rand && ($urandom % 2) != 0) ? 64 : 0));
    for (int a = 0; a < DEPTH; a++)
      wr(a, int'($urandom % 128) & (blink_rand ? 127 : 63));
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int a = 0; a < DEPTH; a++) ram_m[a] = 0;
    for (int r = 0; r < ROWS; r++) row_m[r] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset output", int'(pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 output after release", int'(pix), 0);

    // R1 R5 R7: reset contents, window at the origin
    frame(7);

    // R2 R5 R6 R8: random contents and position
    load_random(0, 64, 0);
    hpos = 6'($urandom % 16); vpos = 6'($urandom % 12);
    wr(200, 5);  // outside both maps
    frame(6);

    // R4: mixed magnification
    hsz = 2'd1; vsz = 2'd2;
    hpos = 6'($urandom % 8); vpos = 6'($urandom % 8);
    frame(20);

    // R4: widest horizontal step
    hsz = 2'd3; vsz = 2'd0; hpos = 6'd3; vpos = 6'd1;
    frame(15);

    // R6: 288 variable cells requested, only 176 entries exist
    hsz = 2'd0;
    load_random(56, 8, 0);
    hpos = 6'd0; vpos = 6'd2;
    frame(6);

    // R9: every row blinkable, fixed cells only
    ben = 1'b1;
    for (int r = 0; r < ROWS; r++) wr(DEPTH + r, 64 | int'($urandom % 32));
    hpos = 6'd2; vpos = 6'd0;
    pulse_vs(31);
    chk("R9 phase still visible after 31 edges", int'(phase_m), 0);
    frame(40);
    pulse_vs(1);
    frame(40);

    // R9: mixed attributes while hidden, then gating disabled
    load_random(0, 64, 1);
    frame(8);
    ben = 1'b0;
    frame(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 195000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule